// File: doc/BRIEF.md
# Eight-lane AES-128 counter-mode keystream engine

This block produces counter-mode ciphertext for eight 128-bit blocks per batch. It works on one batch at a time. When a batch starts, eight consecutive counter values are taken from an internal base register. All eight are whitened with round key 0. They then go through nine full AES rounds and one final round. The final round has no column mixing and uses round key 10. The eight encrypted counters form the keystream. Each is XORed with its own data block, and the eight results are presented together on a wide output.

A single two-stage round pipeline is shared by all eight lanes. The scheduler is round-major. In every cycle of a round it feeds the pipeline the next lane, all with the same round key. Only after all eight lanes have used that key does it move on to the next key. This keeps the pipeline filled on every cycle while a batch is running. The eleven expanded round keys are computed outside the block and written in through a key-load port before use. The counter base is written through its own port. After each batch the base advances by eight on its own, so back-to-back batches continue the keystream.

Top module: `aes_ctr_x8`

## Requirements
- R1: While reset is held and right after it is released, `busy` and `out_valid` are 0 and `out_text` is all zeros.
- R2: Lane i (0..7) encrypts a counter equal to the base with its low 32 bits replaced by (base low 32 + i) mod 2^32. The upper 96 bits of the counter are copied unchanged.
- R3: Each accepted start advances the base by 8 in its low 32 bits modulo 2^32, leaving the upper 96 bits unchanged. The next batch therefore begins at base + 8.
- R4: Each lane is AES-128 encryption of its counter: XOR with round key 0, then rounds 1..9 with full mixing, then round 10 without column mixing. With round keys expanded from key 000102030405060708090a0b0c0d0e0f and counter 00112233445566778899aabbccddeeff, lane 0 is 69c4e0d86a7b0430d8cdb78070b4c55a. Byte 0 of a block is bits [127:120].
- R5: `out_text` bits [128*i+127 : 128*i] hold lane i's keystream XOR the data block in the same position of `data_in`. `data_in` is sampled in the cycle the start is accepted. Block i sits at byte offset 16*i of the output.
- R6: A start sampled while `busy` is 0 is accepted. `busy` is 1 from the next edge onward. `out_valid` is a one-cycle pulse at the 82nd rising edge after the accepting edge, and `busy` falls at that same edge.
- R7: A start sampled while `busy` is 1 is ignored. The running batch keeps its timing and result, and the base is not advanced a second time.
- R8: Key writes while `busy` is 1 are ignored. The stored round keys stay as they were.
- R9: During a batch the shared round pipeline takes one lane per cycle for 80 consecutive cycles. The lane order is 0..7 within each round, and the rounds run 1..10.
- R10: A counter write (`ctr_we`) sets the base only while `busy` is 0. While a batch runs, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| key_we | input | 1 | Round key write strobe |
| key_idx | input | 4 | Round key number 0..10 |
| key_data | input | 128 | Round key value |
| ctr_we | input | 1 | Counter base write strobe |
| ctr_data | input | 128 | Counter base value |
| start | input | 1 | Start a batch when idle |
| data_in | input | 1024 | Eight data blocks, block i at bits 128*i |
| busy | output | 1 | Batch in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_text | output | 1024 | Eight result blocks, block i at bits 128*i |

## Verification
The hardest situation to reach from the ports is a stimulus that lands in the middle of a running batch. That covers a second start, a round-key overwrite and a counter write, all while the pipeline is busy. Each one would corrupt either the lanes still in flight or the following batch. The bench injects all three at a fixed cycle inside a batch. It then checks that the latency and every lane are unchanged, and that the next batch still starts at base + 8 with the original keys. The 32-bit wrap of the counter is reached by choosing base values just below 2^32, both within one batch and across a batch boundary.

// File: rtl/aes_ctr_pkg.sv
package aes_ctr_pkg;
  localparam int BLK_W = 128;
  typedef logic [BLK_W-1:0] blk_t;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = '0;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_xtime(t);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 by repeated squaring
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = gf_mul(a, a);
    acc = sq;
    for (int i = 0; i < 6; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    logic [7:0] r;
    r = v;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  // byte k of a block lives at bits [127-8k -: 8]; row = k%4, column = k/4
  function automatic logic [7:0] get_byte(input blk_t b, input int k);
    return b[BLK_W-1-8*k -: 8];
  endfunction

  function automatic blk_t sub_shift(input blk_t b);
    blk_t o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_W-1-8*(r+4*c) -: 8] = sbox(get_byte(b, r + 4*((c + r) % 4)));
    return o;
  endfunction

  function automatic blk_t mix_cols(input blk_t b);
    blk_t o;
    logic [7:0] a0, a1, a2, a3;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      a0 = get_byte(b, 4*c);
      a1 = get_byte(b, 4*c+1);
      a2 = get_byte(b, 4*c+2);
      a3 = get_byte(b, 4*c+3);
      o[BLK_W-1-8*(4*c)   -: 8] = gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3;
      o[BLK_W-1-8*(4*c+1) -: 8] = a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3;
      o[BLK_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3;
      o[BLK_W-1-8*(4*c+3) -: 8] = gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3);
    end
    return o;
  endfunction

  // counter step: only the low 32 bits move, modulo 2^32
  function automatic blk_t ctr_step(input blk_t base, input logic [31:0] n);
    return {base[BLK_W-1:32], base[31:0] + n};
  endfunction
endpackage

// File: rtl/aes_ctr_round_pipe.sv
module aes_ctr_round_pipe
  import aes_ctr_pkg::*;
#(
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  blk_t              in_blk,
  input  blk_t              in_key,
  input  logic              in_last,
  input  logic [LANE_W-1:0] in_lane,
  output logic              out_valid,
  output blk_t              out_blk,
  output logic              out_last,
  output logic [LANE_W-1:0] out_lane
);
  logic              s1_valid;
  blk_t              s1_blk;
  blk_t              s1_key;
  logic              s1_last;
  logic [LANE_W-1:0] s1_lane;

  // stage 1: byte substitution and row shift
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_blk   <= '0;
      s1_key   <= '0;
      s1_last  <= 1'b0;
      s1_lane  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_blk   <= sub_shift(in_blk);
      s1_key   <= in_key;
      s1_last  <= in_last;
      s1_lane  <= in_lane;
    end
  end

  // stage 2: column mixing (skipped in the final round) and key addition
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_blk   <= '0;
      out_last  <= 1'b0;
      out_lane  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_blk   <= (s1_last ? s1_blk : mix_cols(s1_blk)) ^ s1_key;
      out_last  <= s1_last;
      out_lane  <= s1_lane;
    end
  end

  AST_PIPE_TWO_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R9
  AST_PIPE_LANE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lane == $past(in_lane, 2)); // R9
endmodule

// File: rtl/aes_ctr_sched.sv
module aes_ctr_sched #(
  parameter int LANES  = 8,
  parameter int NR     = 10,
  parameter int LANE_W = 3,
  parameter int KIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  output logic              issue_valid,
  output logic [LANE_W-1:0] issue_lane,
  output logic [KIDX_W-1:0] issue_round,
  output logic              issue_last
);
  localparam logic [LANE_W-1:0] LAST_LANE  = LANE_W'(LANES - 1);
  localparam logic [KIDX_W-1:0] LAST_ROUND = KIDX_W'(NR);

  logic active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      issue_lane  <= '0;
      issue_round <= KIDX_W'(1);
    end else if (launch) begin
      active_q    <= 1'b1;
      issue_lane  <= '0;
      issue_round <= KIDX_W'(1);
    end else if (active_q) begin
      if (issue_lane == LAST_LANE) begin
        issue_lane <= '0;
        if (issue_round == LAST_ROUND) active_q <= 1'b0;
        else issue_round <= issue_round + KIDX_W'(1);
      end else begin
        issue_lane <= issue_lane + LANE_W'(1);
      end
    end
  end

  assign issue_valid = active_q;
  assign issue_last  = (issue_round == LAST_ROUND);

  AST_LANE_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_lane != LAST_LANE && !launch |=>
      issue_valid && issue_lane == $past(issue_lane) + LANE_W'(1)); // R9
  AST_ROUND_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_lane == LAST_LANE && !issue_last && !launch |=>
      issue_valid && issue_lane == '0 && issue_round == $past(issue_round) + KIDX_W'(1)); // R9
  AST_LAUNCH_ROUND1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> issue_valid && issue_lane == '0 && issue_round == KIDX_W'(1)); // R9
endmodule

// File: rtl/aes_ctr_keybank.sv
module aes_ctr_keybank
  import aes_ctr_pkg::*;
#(
  parameter int NK     = 11,
  parameter int KIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [KIDX_W-1:0] wr_idx,
  input  blk_t              wr_key,
  input  logic [KIDX_W-1:0] rd_idx,
  output blk_t              rd_key,
  output blk_t              key0
);
  logic [NK-1:0][BLK_W-1:0] keys_q;
  logic                     wr_ok;

  assign wr_ok = wr_en && !lock && (wr_idx < KIDX_W'(NK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keys_q <= '0;
    end else if (wr_ok) begin
      keys_q[wr_idx] <= wr_key;
    end
  end

  assign rd_key = (rd_idx < KIDX_W'(NK)) ? keys_q[rd_idx] : '0;
  assign key0   = keys_q[0];

  AST_KEYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(keys_q)); // R8
endmodule

// File: rtl/aes_ctr_ctrgen.sv
module aes_ctr_ctrgen
  import aes_ctr_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    advance,
  input  logic                    load,
  input  blk_t                    load_val,
  output logic [LANES-1:0][BLK_W-1:0] lane_ctr
);
  blk_t base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (advance) base_q <= ctr_step(base_q, 32'(LANES));
    else if (load) base_q <= load_val;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_ctr[i] = ctr_step(base_q, 32'(i));
  end

  AST_BASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> base_q[31:0] == $past(base_q[31:0]) + 32'(LANES)
                && base_q[BLK_W-1:32] == $past(base_q[BLK_W-1:32])); // R3
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance && !load |=> $stable(base_q)); // R10
endmodule

// File: rtl/aes_ctr_x8.sv
module aes_ctr_x8
  import aes_ctr_pkg::*;
#(
  parameter int LANES = 8,
  parameter int NR    = 10,
  localparam int NK     = NR + 1,
  localparam int KIDX_W = $clog2(NK),
  localparam int LANE_W = $clog2(LANES),
  localparam int WIDE_W = LANES * BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [KIDX_W-1:0] key_idx,
  input  logic [127:0]      key_data,
  input  logic              ctr_we,
  input  logic [127:0]      ctr_data,
  input  logic              start,
  input  logic [WIDE_W-1:0] data_in,
  output logic              busy,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_text
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic                         launch;
  logic [LANES-1:0][BLK_W-1:0]  lane_ctr;
  logic [LANES-1:0][BLK_W-1:0]  lane_q;
  logic [LANES-1:0][BLK_W-1:0]  data_q;
  blk_t                         key0;
  blk_t                         round_key;
  logic                         issue_valid;
  logic [LANE_W-1:0]            issue_lane;
  logic [KIDX_W-1:0]            issue_round;
  logic                         issue_last;
  logic                         wb_valid;
  blk_t                         wb_blk;
  logic                         wb_last;
  logic [LANE_W-1:0]            wb_lane;
  logic                         batch_done;

  assign launch     = start && !busy;
  assign batch_done = wb_valid && wb_last && (wb_lane == LAST_LANE);

  aes_ctr_ctrgen #(.LANES(LANES)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (launch),
    .load     (ctr_we && !busy),
    .load_val (ctr_data),
    .lane_ctr (lane_ctr)
  );

  aes_ctr_keybank #(.NK(NK), .KIDX_W(KIDX_W)) u_keys (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock   (busy),
    .wr_en  (key_we),
    .wr_idx (key_idx),
    .wr_key (key_data),
    .rd_idx (issue_round),
    .rd_key (round_key),
    .key0   (key0)
  );

  aes_ctr_sched #(.LANES(LANES), .NR(NR), .LANE_W(LANE_W), .KIDX_W(KIDX_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .issue_valid (issue_valid),
    .issue_lane  (issue_lane),
    .issue_round (issue_round),
    .issue_last  (issue_last)
  );

  aes_ctr_round_pipe #(.LANE_W(LANE_W)) u_round (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (issue_valid),
    .in_blk    (lane_q[issue_lane]),
    .in_key    (round_key),
    .in_last   (issue_last),
    .in_lane   (issue_lane),
    .out_valid (wb_valid),
    .out_blk   (wb_blk),
    .out_last  (wb_last),
    .out_lane  (wb_lane)
  );

  // lane state: whitening on launch, round results written back by lane
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
      data_q <= '0;
    end else if (launch) begin
      for (int i = 0; i < LANES; i++) begin
        lane_q[i] <= lane_ctr[i] ^ key0;
        data_q[i] <= data_in[BLK_W*i +: BLK_W];
      end
    end else if (wb_valid) begin
      lane_q[wb_lane] <= wb_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_text  <= '0;
    end else begin
      out_valid <= batch_done;
      if (launch) busy <= 1'b1;
      else if (batch_done) busy <= 1'b0;
      if (batch_done) begin
        for (int i = 0; i < LANES; i++) begin
          out_text[BLK_W*i +: BLK_W] <=
            ((wb_lane == LANE_W'(i)) ? wb_blk : lane_q[i]) ^ data_q[i];
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy && $past(busy)); // R6
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R6
  AST_BUSY_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> !$rose(issue_valid)); // R7
  AST_WB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy); // R9
endmodule

// File: tb/test_aes_ctr_x8.sv
module test_aes_ctr_x8;
  localparam int LANES = 8;
  localparam int W     = LANES * 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          key_we = 1'b0;
  logic [3:0]    key_idx = '0;
  logic [127:0]  key_data = '0;
  logic          ctr_we = 1'b0;
  logic [127:0]  ctr_data = '0;
  logic          start = 1'b0;
  logic [W-1:0]  data_in = '0;
  logic          busy;
  logic          out_valid;
  logic [W-1:0]  out_text;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  aes_ctr_x8 i_aes_ctr_x8 (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_idx(key_idx), .key_data(key_data),
    .ctr_we(ctr_we), .ctr_data(ctr_data), .start(start), .data_in(data_in),
    .busy(busy), .out_valid(out_valid), .out_text(out_text)
  );

  // ---------------- reference model (bench's own formulation) ----------------
  logic [7:0]   sb [256];
  logic [127:0] rk [11];

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  task automatic build_sbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 0;
      logic [7:0] s;
      for (int b = 1; b < 256; b++)
        if (m_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i;
      sb[a] = s;
    end
  endtask

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] st [16];
    logic [7:0] tp [16];
    logic [127:0] o;
    for (int k = 0; k < 16; k++) st[k] = pt[127-8*k -: 8] ^ rk[0][127-8*k -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int k = 0; k < 16; k++) st[k] = sb[st[k]];
      for (int c = 0; c < 4; c++)
        for (int row = 0; row < 4; row++) tp[row+4*c] = st[row + 4*((c+row)%4)];
      for (int c = 0; c < 4; c++)
        for (int row = 0; row < 4; row++)
          if (r == 10) st[row+4*c] = tp[row+4*c];
          else st[row+4*c] = m_mul(tp[4*c+row], 2) ^ m_mul(tp[4*c+(row+1)%4], 3)
                             ^ tp[4*c+(row+2)%4] ^ tp[4*c+(row+3)%4];
      for (int k = 0; k < 16; k++) st[k] ^= rk[r][127-8*k -: 8];
    end
    for (int k = 0; k < 16; k++) o[127-8*k -: 8] = st[k];
    return o;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic load_key(input logic [127:0] key);
    expand(key);
    for (int r = 0; r < 11; r++) begin
      @(negedge clk); key_we = 1'b1; key_idx = 4'(r); key_data = rk[r];
    end
    @(negedge clk); key_we = 1'b0;
  endtask

  task automatic load_ctr(input logic [127:0] c);
    @(negedge clk); ctr_we = 1'b1; ctr_data = c;
    @(negedge clk); ctr_we = 1'b0;
  endtask

  function automatic logic [W-1:0] make_data(input logic [127:0] fill);
    logic [W-1:0] d;
    for (int i = 0; i < LANES; i++) d[128*i +: 128] = fill ^ {16{8'(i*17)}};
    return d;
  endfunction

  // runs one batch; poke injects start/key/ctr writes in the middle of it
  task automatic run_batch(input string tag, input logic [127:0] base,
                           input logic [127:0] fill, input bit poke);
    int lat = 0;
    logic [W-1:0] d = make_data(fill);
    @(negedge clk); start = 1'b1; data_in = d;
    @(negedge clk); start = 1'b0; data_in = ~d;
    chk({tag, " R6 busy after accept"}, 128'(busy), 128'd1);
    while (!out_valid && lat < 300) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 20) begin
        start = 1'b1; key_we = 1'b1; key_idx = 4'd5; key_data = ~rk[5];
        ctr_we = 1'b1; ctr_data = 128'hdead;
      end else if (poke && lat == 21) begin
        start = 1'b0; key_we = 1'b0; ctr_we = 1'b0;
      end
    end
    chk({tag, " R6 latency"}, 128'(lat), 128'd82);
    chk({tag, " R6 busy low at done"}, 128'(busy), 128'd0);
    for (int i = 0; i < LANES; i++) begin
      logic [127:0] c = {base[127:32], base[31:0] + 32'(i)};
      chk({tag, " R2 R5 lane"}, out_text[128*i +: 128], ref_enc(c) ^ d[128*i +: 128]);
    end
    @(negedge clk);
    chk({tag, " R6 pulse width"}, 128'(out_valid), 128'd0);
  endtask

  localparam logic [383:0] VEC [4] = '{
    {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 128'h0},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hf0f1f2f3f4f5f6f7f8f9fafbfcfdfeff,
     128'h6bc1bee22e409f96e93d7e117393172a},
    {128'h8e73b0f7da0e6452c810f32b809079e5, 128'h0123456789abcdef01234567fffffffc,
     128'hae2d8a571e03ac9c9eb76fac45af8e51},
    {128'h603deb1015ca71be2b73aef0857d7781, 128'hffffffffffffffffffffffffffffffff,
     128'h30c81c46a35ce411e5fbc1191a0a52ef}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R6 act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] base;
    build_sbox();
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 128'(busy), 128'd0);
    chk("R1 out_valid in reset", 128'(out_valid), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 128'(busy), 128'd0);
    chk("R1 out_valid after reset", 128'(out_valid), 128'd0);
    chk("R1 out_text after reset", out_text[127:0] | out_text[W-1:W-128], 128'd0);

    // table walk: one batch per vector
    for (int v = 0; v < 4; v++) begin
      load_key(VEC[v][383:256]);
      load_ctr(VEC[v][255:128]);
      run_batch("vec", VEC[v][255:128], VEC[v][127:0], 1'b0);
      if (v == 0)
        chk("R4 known answer lane0", out_text[127:0], 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    end

    // R3: next batch continues at base+8 with upper bits kept (wrap of vec 3)
    base = {VEC[3][255:160], VEC[3][159:128] + 32'd8};
    run_batch("R3 chained", base, 128'h0, 1'b0);

    // R3 wrap across a batch boundary
    load_ctr(128'hcafef00d_12345678_9abcdef0_fffffff8);
    run_batch("R3 pre-wrap", 128'hcafef00d_12345678_9abcdef0_fffffff8, 128'h5, 1'b0);
    run_batch("R3 post-wrap", 128'hcafef00d_12345678_9abcdef0_00000000, 128'h7, 1'b0);

    // R7 R8 R10: start, key write and counter write during a running batch
    load_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    load_ctr(128'h11111111_22222222_33333333_44444444);
    run_batch("R7 R8 R10 poke", 128'h11111111_22222222_33333333_44444444, 128'h9, 1'b1);
    run_batch("R7 R8 R10 after poke", 128'h11111111_22222222_33333333_4444444c, 128'ha, 1'b0);

    summary();
    $finish;
  end
endmodule